// File: doc/BRIEF.md
# Command Semaphore Execution Controller

This block accepts commands from a host processor and executes them on an internal sequencer that other agents also use. The host writes an opcode and a channel number in one cycle. If the controller is idle, the write is captured and a busy semaphore rises. The controller clears that semaphore itself, and only once the command has finished executing.

The sequencer is shared by three agents under a fixed priority:

1. Memory refresh, which is highest.
2. Command execution.
3. Serial channel servicing, which is lowest.

Refresh may take the sequencer from a running command. The command's progress counter then pauses and resumes where it stopped; it does not start over. A channel service that already holds the sequencer always runs to its end, so neither a new command nor a refresh can interrupt it.

The resynchronisation (hunt) command runs for a long, fixed number of cycles. Every other command runs for a shorter fixed number of cycles. When a command completes, the block emits a one-cycle completion pulse carrying the finished opcode and channel. The refresh requester and the channel service requester are modelled only as request/grant pairs.

Top module: `cmdsem_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the busy flag, the overrun flag, the done pulse, both grants and `cmd_run`; a reset taken while a command is running abandons that command.
- R2: A host write sampled while the busy flag is 0 sets the busy flag in the next cycle and captures `host_op` and `host_ch`; `cmd_run` is only ever high while the busy flag is 1.
- R3: A host write sampled while the busy flag is 1 is ignored: the captured opcode and channel stay unchanged. Such a write sets the overrun flag, which then stays at 1 until reset. This includes a write on the same edge at which the flag falls.
- R4: With the sequencer otherwise free, opcode value 3 (hunt) holds `cmd_run` for exactly 41 cycles and every other opcode for exactly 19. The busy flag is then high for the run length plus one cycle.
- R5: `done_pulse` is high for exactly one cycle, namely the first cycle in which the busy flag reads 0 after being 1. During that cycle, `done_op` and `done_ch` show the completed command.
- R6: At most one of `rfsh_gnt`, `svc_gnt` and `cmd_run` is high in any cycle. When the sequencer is free, the order of precedence is refresh, then a pending command, then channel service. A refresh request sampled while no channel service holds the sequencer gives `rfsh_gnt` in the next cycle.
- R7: A refresh that takes the sequencer from a running command pauses the command's cycle count. The command still runs its full length in total, and the busy flag stays high longer by the number of refresh cycles.
- R8: A channel service that holds the sequencer keeps it for as long as `svc_req` stays high, even against a pending command or a refresh request. A pending command starts in the cycle after the service is released.
- R9: Each grant is registered, so a grant is only high in a cycle if its request was high at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Host write strobe for the command register |
| host_op | input | OP_W | Opcode to execute (3 = hunt) |
| host_ch | input | CH_W | Channel number the command targets |
| busy_flag | output | 1 | Semaphore: 1 while a command is held or running |
| overrun | output | 1 | Sticky: a write arrived while busy |
| done_pulse | output | 1 | One-cycle completion strobe |
| done_op | output | OP_W | Opcode of the completed command |
| done_ch | output | CH_W | Channel of the completed command |
| rfsh_req | input | 1 | Refresh request |
| rfsh_gnt | output | 1 | Sequencer granted to refresh |
| svc_req | input | 1 | Channel service request; held high for the whole service |
| svc_gnt | output | 1 | Sequencer granted to channel service |
| cmd_run | output | 1 | Sequencer executing the held command |

## Verification
The bound checker watches several properties on every cycle:

- Exclusive grant ownership.
- Refresh precedence over a command that can be preempted.
- Grants following their requests by one cycle.
- Service hold.
- The sticky overrun flag.
- The tie between the falling flag and the done pulse.
- The exact number of run cycles per opcode at completion.

Some behaviour can only be shown by the bench scenarios. These scenarios check:

- That a write arriving while busy really leaves the captured command unchanged.
- The total stretch of the busy flag when a service or refresh delays or interrupts a command.
- That a write on the edge where the flag falls is dropped.

// File: rtl/cmdsem_pkg.sv
// Package: shared types for the command semaphore controller.
// Holds the sequencer owner encoding and the fixed-priority pick used by
// the arbiter. Assumes exactly three requesters plus an idle state.
package cmdsem_pkg;

    typedef enum logic [1:0] {
        OWN_IDLE = 2'd0,
        OWN_RFSH = 2'd1,
        OWN_CMD  = 2'd2,
        OWN_SVC  = 2'd3
    } owner_e;

    // Fixed priority among free-running requests: refresh, command, service.
    function automatic owner_e pick_owner(input logic rfsh, input logic cmd, input logic svc);
        if (rfsh)     return OWN_RFSH;
        else if (cmd) return OWN_CMD;
        else if (svc) return OWN_SVC;
        else          return OWN_IDLE;
    endfunction

endpackage

// File: rtl/cmdsem_hostif.sv
// Module: host side of the controller.
// Captures a command when the semaphore is clear, raises the semaphore,
// records a sticky overrun on writes while busy, and clears the semaphore
// with a one-cycle done strobe when the executor reports completion.
// Assumes finish is only asserted while busy is set.
module cmdsem_hostif #(
    parameter int OP_W = 4,
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr,
    input  logic [OP_W-1:0] host_op,
    input  logic [CH_W-1:0] host_ch,
    input  logic            finish,
    output logic            busy,
    output logic            overrun,
    output logic            done,
    output logic [OP_W-1:0] cur_op,
    output logic [CH_W-1:0] cur_ch
);

    logic accept;

    // Decide whether this cycle's write is taken.
    always_comb begin
        accept = host_wr && !busy;
    end

    // Semaphore: set by an accepted write, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (finish) begin
            busy <= 1'b0;
        end else if (accept) begin
            busy <= 1'b1;
        end
    end

    // Command holding register, loaded only by an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_op <= '0;
            cur_ch <= '0;
        end else if (accept) begin
            cur_op <= host_op;
            cur_ch <= host_ch;
        end
    end

    // Sticky overrun on any write that finds the semaphore set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (host_wr && busy) begin
            overrun <= 1'b1;
        end
    end

    // Completion strobe, aligned with the semaphore falling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= finish;
        end
    end

endmodule

// File: rtl/cmdsem_arbiter.sv
// Module: fixed-priority owner register for the shared sequencer.
// Refresh beats a pending command, which beats channel service. A service
// owner keeps the sequencer while its request stays high; a command owner
// yields to refresh and re-arbitrates on completion.
// Assumes cmd_pend is the registered semaphore and finish the executor's
// completion for the current cycle.
module cmdsem_arbiter
    import cmdsem_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rfsh_req,
    input  logic   svc_req,
    input  logic   cmd_pend,
    input  logic   finish,
    output owner_e owner
);

    owner_e nxt_owner;
    owner_e free_pick;
    logic   cmd_wants;

    // Next owner: a holding service is sticky, everything else re-picks.
    always_comb begin
        cmd_wants = cmd_pend && !finish;
        free_pick = pick_owner(rfsh_req, cmd_wants, svc_req);
        case (owner)
            OWN_SVC: nxt_owner = svc_req ? OWN_SVC : free_pick;
            default: nxt_owner = free_pick;
        endcase
    end

    // Owner register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner <= OWN_IDLE;
        end else begin
            owner <= nxt_owner;
        end
    end

endmodule

// File: rtl/cmdsem_exec.sv
// Module: per-opcode execution timer.
// Counts cycles in which the command owns the sequencer. It holds its count
// while preempted and signals finish in the last run cycle. The hunt opcode
// runs HUNT_LEN cycles and all others STD_LEN. Assumes op is stable while
// a command is held.
module cmdsem_exec #(
    parameter int          OP_W     = 4,
    parameter logic [OP_W-1:0] HUNT_OP = 4'd3,
    parameter int          HUNT_LEN = 41,
    parameter int          STD_LEN  = 19
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [OP_W-1:0] op,
    output logic            finish
);

    localparam int MAX_LEN = (HUNT_LEN > STD_LEN) ? HUNT_LEN : STD_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] last_idx;

    // Last cycle index for the held opcode.
    always_comb begin
        last_idx = (op == HUNT_OP) ? CNT_W'(HUNT_LEN - 1) : CNT_W'(STD_LEN - 1);
        finish   = run && (elapsed == last_idx);
    end

    // Run-cycle counter: advance while running, hold while preempted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (finish) begin
            elapsed <= '0;
        end else if (run) begin
            elapsed <= elapsed + 1'b1;
        end
    end

endmodule

// File: rtl/cmdsem_ctrl.sv
// Module: top of the command semaphore execution controller.
// Connects the host register, the execution timer and the three-way
// sequencer arbiter, and brings out grants and the completion report.
// Assumes the refresh and service requesters hold their requests for as
// long as they need the sequencer.
module cmdsem_ctrl #(
    parameter int              OP_W     = 4,
    parameter int              CH_W     = 2,
    parameter logic [OP_W-1:0] HUNT_OP  = 4'd3,
    parameter int              HUNT_LEN = 41,
    parameter int              STD_LEN  = 19
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr,
    input  logic [OP_W-1:0] host_op,
    input  logic [CH_W-1:0] host_ch,
    output logic            busy_flag,
    output logic            overrun,
    output logic            done_pulse,
    output logic [OP_W-1:0] done_op,
    output logic [CH_W-1:0] done_ch,
    input  logic            rfsh_req,
    output logic            rfsh_gnt,
    input  logic            svc_req,
    output logic            svc_gnt,
    output logic            cmd_run
);

    import cmdsem_pkg::*;

    owner_e          owner;
    logic            finish;
    logic [OP_W-1:0] cur_op;
    logic [CH_W-1:0] cur_ch;

    cmdsem_hostif #(.OP_W(OP_W), .CH_W(CH_W)) u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .host_wr (host_wr),
        .host_op (host_op),
        .host_ch (host_ch),
        .finish  (finish),
        .busy    (busy_flag),
        .overrun (overrun),
        .done    (done_pulse),
        .cur_op  (cur_op),
        .cur_ch  (cur_ch)
    );

    cmdsem_exec #(
        .OP_W     (OP_W),
        .HUNT_OP  (HUNT_OP),
        .HUNT_LEN (HUNT_LEN),
        .STD_LEN  (STD_LEN)
    ) u_exec (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cmd_run),
        .op     (cur_op),
        .finish (finish)
    );

    cmdsem_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rfsh_req (rfsh_req),
        .svc_req  (svc_req),
        .cmd_pend (busy_flag),
        .finish   (finish),
        .owner    (owner)
    );

    // Decode the owner into the outward grants and the run indication.
    always_comb begin
        rfsh_gnt = (owner == OWN_RFSH);
        svc_gnt  = (owner == OWN_SVC);
        cmd_run  = (owner == OWN_CMD);
        done_op  = cur_op;
        done_ch  = cur_ch;
    end

endmodule

// File: rtl/cmdsem_ctrl_chk.sv
// Module: property checker for cmdsem_ctrl, attached by bind.
// Observes only top-level ports. Keeps one counter of run cycles per
// command so that the length check needs no long delays.
module cmdsem_ctrl_chk #(
    parameter int              OP_W     = 4,
    parameter logic [OP_W-1:0] HUNT_OP  = 4'd3,
    parameter int              HUNT_LEN = 41,
    parameter int              STD_LEN  = 19
) (
    input logic            clk,
    input logic            rst_n,
    input logic            host_wr,
    input logic            busy_flag,
    input logic            overrun,
    input logic            done_pulse,
    input logic [OP_W-1:0] done_op,
    input logic            rfsh_req,
    input logic            rfsh_gnt,
    input logic            svc_req,
    input logic            svc_gnt,
    input logic            cmd_run
);

    int unsigned run_seen;

    // Count run cycles of the current command; restart after completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_seen <= 0;
        end else if (done_pulse) begin
            run_seen <= 0;
        end else if (cmd_run) begin
            run_seen <= run_seen + 1;
        end
    end

    p_run_needs_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_run |-> busy_flag);

    p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && busy_flag) |=> overrun);

    p_overrun_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    p_run_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (run_seen == ((done_op == HUNT_OP) ? HUNT_LEN : STD_LEN)));

    p_done_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_flag) |-> done_pulse);

    p_done_flag_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (!busy_flag && $past(busy_flag)));

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    p_one_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rfsh_gnt, svc_gnt, cmd_run}));

    p_rfsh_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_req && !svc_gnt) |=> rfsh_gnt);

    p_svc_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_gnt && svc_req) |=> svc_gnt);

    p_rfsh_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_gnt |-> $past(rfsh_req));

    p_svc_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        svc_gnt |-> $past(svc_req));

endmodule

bind cmdsem_ctrl cmdsem_ctrl_chk #(
    .OP_W     (OP_W),
    .HUNT_OP  (HUNT_OP),
    .HUNT_LEN (HUNT_LEN),
    .STD_LEN  (STD_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .busy_flag  (busy_flag),
    .overrun    (overrun),
    .done_pulse (done_pulse),
    .done_op    (done_op),
    .rfsh_req   (rfsh_req),
    .rfsh_gnt   (rfsh_gnt),
    .svc_req    (svc_req),
    .svc_gnt    (svc_gnt),
    .cmd_run    (cmd_run)
);

// File: tb/cmdsem_ctrl_tb_top.sv
// Bench for cmdsem_ctrl. It walks a table of scenarios and then runs
// directed tests. Inputs are driven and outputs sampled on the falling edge.
module cmdsem_ctrl_tb_top;

    localparam int OP_W = 4;
    localparam int CH_W = 2;
    localparam int HUNT = 3;

    typedef struct packed {
        logic [3:0] op;
        logic [1:0] ch;
        logic [7:0] svc_len;   // service held for edges 0..svc_len-1
        logic [7:0] rf_at;     // first edge with refresh request, 0 = none
        logic [7:0] rf_len;    // refresh request edges
        logic [7:0] exp_busy;  // expected busy-high cycles
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{4'd3, 2'd1, 8'd0,  8'd0, 8'd0,  8'd42},
        '{4'd5, 2'd2, 8'd0,  8'd0, 8'd0,  8'd20},
        '{4'd0, 2'd3, 8'd0,  8'd0, 8'd0,  8'd20},
        '{4'd3, 2'd0, 8'd0,  8'd6, 8'd4,  8'd46},
        '{4'd9, 2'd1, 8'd0,  8'd5, 8'd25, 8'd45},
        '{4'd7, 2'd2, 8'd10, 8'd0, 8'd0,  8'd28},
        '{4'd3, 2'd3, 8'd6,  8'd0, 8'd0,  8'd46},
        '{4'd1, 2'd0, 8'd0,  8'd1, 8'd3,  8'd22},
        '{4'd2, 2'd1, 8'd5,  8'd3, 8'd4,  8'd25}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            host_wr = 1'b0;
    logic [OP_W-1:0] host_op = '0;
    logic [CH_W-1:0] host_ch = '0;
    logic            busy_flag, overrun, done_pulse;
    logic [OP_W-1:0] done_op;
    logic [CH_W-1:0] done_ch;
    logic            rfsh_req = 1'b0;
    logic            rfsh_gnt;
    logic            svc_req = 1'b0;
    logic            svc_gnt;
    logic            cmd_run;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cmdsem_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_op(host_op), .host_ch(host_ch),
        .busy_flag(busy_flag), .overrun(overrun), .done_pulse(done_pulse),
        .done_op(done_op), .done_ch(done_ch), .rfsh_req(rfsh_req), .rfsh_gnt(rfsh_gnt),
        .svc_req(svc_req), .svc_gnt(svc_gnt), .cmd_run(cmd_run)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One table scenario. Loop step n samples the state after edge n-1 and
    // then drives the inputs for edge n.
    task automatic run_vec(input vec_t cv);
        int    len = (cv.op == HUNT) ? 41 : 19;
        int    busy_cnt = 0;
        int    run_cnt = 0;
        int    done_cnt = 0;
        logic  prev_busy = 1'b0;
        string tag = (cv.rf_len != 0) ? "R7" : ((cv.svc_len != 0) ? "R8" : "R4");
        for (int n = 0; n < 90; n++) begin
            @(negedge clk);
            if (busy_flag) busy_cnt++;
            if (cmd_run) run_cnt++;
            if (done_pulse) begin
                done_cnt++;
                check("R5", "flag low at done", int'(busy_flag), 0);
                check("R5", "flag high before done", int'(prev_busy), 1);
                check("R5", "done_op", int'(done_op), int'(cv.op));
                check("R5", "done_ch", int'(done_ch), int'(cv.ch));
            end
            prev_busy = busy_flag;
            host_wr  = (n == 1);
            host_op  = cv.op;
            host_ch  = cv.ch;
            svc_req  = (n < int'(cv.svc_len));
            rfsh_req = (cv.rf_at != 0) && (n >= int'(cv.rf_at)) &&
                       (n < int'(cv.rf_at) + int'(cv.rf_len));
        end
        check(tag, "busy cycles", busy_cnt, int'(cv.exp_busy));
        check(tag, "run cycles", run_cnt, len);
        check("R5", "done pulses", done_cnt, 1);
        check("R2", "no overrun on clean write", int'(overrun), 0);
    endtask

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int busy_cnt;
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "busy after reset", int'(busy_flag), 0);
        check("R1", "overrun after reset", int'(overrun), 0);
        check("R1", "done after reset", int'(done_pulse), 0);
        check("R1", "grants after reset", int'({rfsh_gnt, svc_gnt, cmd_run}), 0);

        // Table walk: R4, R5, R7, R8
        for (int v = 0; v < NV; v++) begin
            run_vec(VECS[v]);
        end

        // R6/R9: priority and hold among the requesters with no command held
        @(negedge clk);
        rfsh_req = 1'b1;
        svc_req  = 1'b1;
        #1;
        check("R9", "no grant before edge", int'({rfsh_gnt, svc_gnt}), 0);
        @(negedge clk);
        check("R6", "refresh beats service", int'({rfsh_gnt, svc_gnt}), 2);
        rfsh_req = 1'b0;
        @(negedge clk);
        check("R6", "service after refresh", int'({rfsh_gnt, svc_gnt}), 1);
        rfsh_req = 1'b1;
        @(negedge clk);
        check("R8", "service keeps sequencer", int'({rfsh_gnt, svc_gnt}), 1);
        svc_req = 1'b0;
        @(negedge clk);
        check("R6", "refresh after service", int'({rfsh_gnt, svc_gnt}), 2);
        rfsh_req = 1'b0;
        @(negedge clk);
        check("R9", "grants drop", int'({rfsh_gnt, svc_gnt, cmd_run}), 0);

        // R3: write while busy is ignored and sets sticky overrun
        host_wr = 1'b1; host_op = 4'd3; host_ch = 2'd1;
        @(negedge clk);
        check("R2", "flag set by write", int'(busy_flag), 1);
        host_op = 4'd5; host_ch = 2'd2;
        @(negedge clk);
        host_wr = 1'b0;
        check("R3", "overrun set", int'(overrun), 1);
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            if (done_pulse) begin
                check("R3", "ignored write op", int'(done_op), 3);
                check("R3", "ignored write ch", int'(done_ch), 1);
            end
        end
        check("R3", "overrun sticky", int'(overrun), 1);

        // R3 boundary: write on the edge where the flag falls (edge 21, L=19)
        busy_cnt = 0;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            if (n == 22) check("R3", "flag low after fall-edge write", int'(busy_flag), 0);
            if (n == 23) check("R3", "fall-edge write dropped", int'(busy_flag), 0);
            if (n == 26) check("R2", "later write accepted", int'(busy_flag), 1);
            if (n < 24 && busy_flag) busy_cnt++;
            host_wr = (n == 1) || (n == 21) || (n == 25);
            host_op = 4'd1;
            host_ch = 2'd0;
        end
        check("R4", "standard command busy cycles", busy_cnt, 20);

        // R1: reset in the middle of a running command
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", "busy cleared mid-command", int'(busy_flag), 0);
        check("R1", "overrun cleared", int'(overrun), 0);
        check("R1", "run cleared", int'(cmd_run), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after reset release", int'({busy_flag, done_pulse, rfsh_gnt, svc_gnt}), 0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule